// File: doc/BRIEF.md
# PLL Output Frequency Decoder

This block works out the output frequency, in hertz, of one PLL-driven clock channel. Along with a request strobe it is given four things: the channel to decode, the boot-configuration word, the channel's divider control word and its PLL setting word. It also receives four candidate input frequencies: bus, reference, crystal and CPU. It picks the input frequency named by the channel's source field, applies the multiply rule that the bypass bit, the PLL mode bit and the two divide-mode bits select, and divides by the product of the pre- and post-dividers.

The multiply stage runs in the accepting cycle, with 32-bit truncation. The quotient is then produced by a restoring divider that retires one bit per cycle. When the quotient is ready, a one-cycle `done` pulse is raised, and the result stays on `freq_hz` until the next result replaces it. The block takes one request at a time. Firmware-style users or a boot sequencer drive it to learn the clock rates a set of register values implies.

Top module: `pll_freq_decoder`

## Requirements
- R1: The input frequency is picked by a 2-bit source code in `boot_word`. The field's position depends on `chan_sel`: 0 reads bits 15:14, 1 reads bits 17:16, 2 reads bits 19:18, 3 reads bits 23:22. Code 0 selects `bus_hz`, 1 selects `ref_hz`, 2 selects `xtal_hz` and 3 selects `cpu_hz`. Fields of the other channels have no effect.
- R2: The divisor is (`ctrl_word`[20:16]+1) times (`ctrl_word`[4:0]+1). The result is the integer quotient, truncated.
- R3: When `boot_word`[5] is 1, the result is input/divisor, whatever the PLL word holds. This rule has the highest priority.
- R4: Otherwise, when `pll_word`[0] is 0, the result is (input>>2)/divisor if the multiplier (`pll_word`[15:12]+1) is 16, and (input>>1)/divisor otherwise.
- R5: Otherwise, when `pll_word`[11] and `pll_word`[1] are both 1, the numerator depends on the multiplier m. For odd m it is the low 32 bits of input*m, shifted right by 1. For even m it is the low 32 bits of input*(m-1), shifted right by 2.
- R6: Otherwise, the numerator is the input when m is 16, and the low 32 bits of input*m for any other m.
- R7: A request is accepted on a rising edge where `in_valid` is 1 and `busy` is 0. `done` is high for exactly one cycle, after the 33rd rising edge counting the accepting edge as the first. `freq_hz` changes only together with `done` and holds its value after it.
- R8: `in_valid` and the input values are ignored while `busy` is 1. They change neither the pending result nor its timing, and they raise no extra `done`.
- R9: `busy` is 1 from the accepting edge until the edge that raises `done`, and it is never 1 together with `done`.
- R10: A request presented in the cycle where `done` is high is accepted. It starts a new computation at once.
- R11: While `rst_n` is 0, `busy`, `done` and `freq_hz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| chan_sel | input | 2 | Channel whose source field is decoded |
| boot_word | input | 32 | Boot-configuration word |
| ctrl_word | input | 32 | Divider control word |
| pll_word | input | 32 | PLL setting word |
| bus_hz | input | 32 | Bus clock frequency |
| ref_hz | input | 32 | Reference clock frequency |
| xtal_hz | input | 32 | Crystal frequency |
| cpu_hz | input | 32 | CPU clock frequency |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| freq_hz | output | 32 | Computed output frequency |

## Verification
Two events can fall in the same cycle: the completion pulse of one request and the acceptance of the next. The bench provokes this by holding `in_valid` high in the very cycle `done` is seen. It then confirms three things: the old result is present during that cycle, `busy` returns on the following edge with `done` low, and the second result arrives a full latency later with the new value. A request strobed in the middle of a division checks the opposite case. It must not disturb the pending result or its timing, and it must produce no second pulse.

// File: rtl/pll_freq_decoder.sv
module pll_freq_decoder #(
  parameter int DW = 32,
  parameter int FW = 5,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    chan_sel,
  input  logic [31:0]   boot_word,
  input  logic [31:0]   ctrl_word,
  input  logic [31:0]   pll_word,
  input  logic [DW-1:0] bus_hz,
  input  logic [DW-1:0] ref_hz,
  input  logic [DW-1:0] xtal_hz,
  input  logic [DW-1:0] cpu_hz,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] freq_hz
);
  localparam int DVW = 2 * (FW + 1);
  localparam int CW  = $clog2(DW);
  localparam int PW  = DW + MW + 1;

  logic [1:0]    src;
  logic [DW-1:0] base;
  logic [FW:0]   pre, post;
  logic [DVW-1:0] divisor;
  logic [MW:0]   mul;
  logic          mul_top;
  logic [PW-1:0] prod_m, prod_m1;
  logic [DW-1:0] numer;

  always_comb begin
    case (chan_sel)
      2'd0:    src = boot_word[15:14];
      2'd1:    src = boot_word[17:16];
      2'd2:    src = boot_word[19:18];
      default: src = boot_word[23:22];
    endcase
    case (src)
      2'd0:    base = bus_hz;
      2'd1:    base = ref_hz;
      2'd2:    base = xtal_hz;
      default: base = cpu_hz;
    endcase
  end

  assign pre     = {1'b0, ctrl_word[16 +: FW]} + 1'b1;
  assign post    = {1'b0, ctrl_word[0 +: FW]} + 1'b1;
  assign divisor = DVW'(pre * post);
  assign mul     = {1'b0, pll_word[12 +: MW]} + 1'b1;
  assign mul_top = mul[MW];
  assign prod_m  = PW'(base) * PW'(mul);
  assign prod_m1 = PW'(base) * PW'(pll_word[12 +: MW]);

  always_comb begin
    if (boot_word[5])
      numer = base;
    else if (!pll_word[0])
      numer = mul_top ? (base >> 2) : (base >> 1);
    else if (pll_word[11] && pll_word[1])
      numer = mul[0] ? (prod_m[DW-1:0] >> 1) : (prod_m1[DW-1:0] >> 2);
    else if (mul_top)
      numer = base;
    else
      numer = prod_m[DW-1:0];
  end

  logic           unused_bits;
  assign unused_bits = &{1'b0, boot_word[31:24], boot_word[13:6], boot_word[4:0],
                         ctrl_word[31:16+FW], ctrl_word[15:FW],
                         pll_word[31:12+MW], pll_word[10:2]};

  logic [DW-1:0]  quo;
  logic [DVW-1:0] rem, dvr;
  logic [CW-1:0]  step;
  logic [DVW:0]   trial, diff;
  logic           ge;

  assign trial = {rem, quo[DW-1]};
  assign diff  = trial - {1'b0, dvr};
  assign ge    = trial >= {1'b0, dvr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      freq_hz <= '0;
      quo     <= '0;
      rem     <= '0;
      dvr     <= '0;
      step    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          busy <= 1'b1;
          quo  <= numer;
          dvr  <= divisor;
          rem  <= '0;
          step <= '0;
        end
      end else begin
        quo  <= {quo[DW-2:0], ge};
        rem  <= ge ? diff[DVW-1:0] : trial[DVW-1:0];
        step <= step + 1'b1;
        if (step == CW'(DW - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          freq_hz <= {quo[DW-2:0], ge};
        end
      end
    end
  end
endmodule

// File: rtl/pll_freq_decoder_chk.sv
module pll_freq_decoder_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] freq_hz
);
  logic [7:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                lat_cnt <= '0;
    else if (in_valid && !busy) lat_cnt <= '0;
    else if (busy)              lat_cnt <= lat_cnt + 1'b1;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_cnt == 8'(DW));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_hz) |-> done);

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat_cnt < 8'(DW - 1)) |=> (busy && !done));
endmodule

bind pll_freq_decoder pll_freq_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .busy(busy), .done(done), .freq_hz(freq_hz)
);

// File: tb/pll_freq_decoder_bench.sv
module pll_freq_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  chan_sel = '0;
  logic [31:0] boot_word = '0, ctrl_word = '0, pll_word = '0;
  logic [31:0] bus_hz = 32'd1000000, ref_hz = 32'd2400000;
  logic [31:0] xtal_hz = 32'd720000, cpu_hz = 32'd3600000;
  logic        busy, done;
  logic [31:0] freq_hz;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pll_freq_decoder u_pll_freq_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chan_sel(chan_sel),
    .boot_word(boot_word), .ctrl_word(ctrl_word), .pll_word(pll_word),
    .bus_hz(bus_hz), .ref_hz(ref_hz), .xtal_hz(xtal_hz), .cpu_hz(cpu_hz),
    .busy(busy), .done(done), .freq_hz(freq_hz)
  );

  localparam int NV = 9;
  localparam logic [1:0]  V_CH  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3, 2'd1};
  localparam logic [31:0] V_BOOT[NV] = '{32'h34020, 32'h2C000, 32'h4C0000, 32'h80000, 32'h8000,
                                         32'h10000, 32'h10000, 32'hC00000, 32'h30020};
  localparam logic [31:0] V_CTRL[NV] = '{32'h10002, 32'h0, 32'h3, 32'h40000, 32'h20001,
                                         32'h1F, 32'h1F001F, 32'h0, 32'h30000};
  localparam logic [31:0] V_PLL [NV] = '{32'h4803, 32'h3000, 32'hF000, 32'h4803, 32'h5803,
                                         32'hF001, 32'h7001, 32'h2801, 32'h4803};
  localparam logic [31:0] V_EXP [NV] = '{32'd400000, 32'd360000, 32'd225000, 32'd500000, 32'd150000,
                                         32'd75000, 32'd7812, 32'd10800000, 32'd900000};
  localparam string V_TAG[NV] = '{"R3 R1", "R4 R1", "R4 R1", "R5 R1", "R5 R2",
                                  "R6", "R2 R6", "R6", "R3"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] ch, input logic [31:0] b, input logic [31:0] c,
                        input logic [31:0] p);
    chan_sel = ch; boot_word = b; ctrl_word = c; pll_word = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic await(inout int n);
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run(input logic [1:0] ch, input logic [31:0] b, input logic [31:0] c,
                     input logic [31:0] p, input logic [31:0] exp, input string tag);
    int n;
    @(negedge clk);
    launch(ch, b, c, p);
    n = 1;
    await(n);
    check({tag, " value"}, freq_hz, exp);
    check("R7 latency", 32'(n), 32'd33);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R11 busy", 32'(busy), 0);
    check("R11 done", 32'(done), 0);
    check("R11 freq", freq_hz, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run(V_CH[i], V_BOOT[i], V_CTRL[i], V_PLL[i], V_EXP[i], V_TAG[i]);

    // R5 / R6 truncation of the product to 32 bits
    cpu_hz = 32'h4000_0000;
    run(2'd1, 32'h30000, 32'h0, 32'h4803, 32'h2000_0000, "R5 trunc");
    run(2'd1, 32'h30000, 32'h0, 32'h7001, 32'h0, "R6 trunc");
    cpu_hz = 32'd3600000;

    // R9 busy / R8 ignored request while busy
    @(negedge clk);
    launch(V_CH[0], V_BOOT[0], V_CTRL[0], V_PLL[0]);
    n = 1;
    check("R9 busy after accept", 32'(busy), 1);
    repeat (4) begin @(negedge clk); n++; end
    chan_sel = V_CH[7]; boot_word = V_BOOT[7]; ctrl_word = V_CTRL[7]; pll_word = V_PLL[7];
    in_valid = 1'b1;
    @(negedge clk); n++;
    in_valid = 1'b0;
    await(n);
    check("R8 value", freq_hz, V_EXP[0]);
    check("R8 latency", 32'(n), 32'd33);
    check("R9 busy low at done", 32'(busy), 0);
    begin
      int extra = 0;
      repeat (40) begin @(negedge clk); if (done) extra++; end
      check("R8 no extra done", 32'(extra), 0);
    end
    check("R7 hold", freq_hz, V_EXP[0]);

    // R10 back-to-back: request in the done cycle
    @(negedge clk);
    launch(V_CH[3], V_BOOT[3], V_CTRL[3], V_PLL[3]);
    n = 1;
    await(n);
    check("R10 first value", freq_hz, V_EXP[3]);
    check("R10 first done", 32'(done), 1);
    launch(V_CH[4], V_BOOT[4], V_CTRL[4], V_PLL[4]);
    check("R10 done dropped", 32'(done), 0);
    check("R10 busy again", 32'(busy), 1);
    n = 1;
    await(n);
    check("R10 second value", freq_hz, V_EXP[4]);
    check("R10 second latency", 32'(n), 32'd33);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule